// File: doc/BRIEF.md
# Two-Band Hearing-Aid Filter Datapath

This block is a pipelined fixed-point datapath that reshapes a stream of 16-bit signed audio samples for a simple hearing aid. It keeps the last four accepted samples in a flip-flop delay line. From the newest sample and the one four samples back it forms two terms using wired shifts and adds only. The pass-band term is half of their difference and the rejection term is half of their sum. Each term is weighted by programmable 4-bit gains. The rejection term is then subtracted from the pass-band term, and the remainder is scaled by a 4-bit volume code. The result is a 24-bit signed output sample.

Every gain and volume multiply is a narrow shift-and-select unit. The unit forms the wide operand times 1, 2, 4 and 8, lets each multiplier bit pass or block one of those copies, and adds the selected copies. There are no general multipliers. A host presents one sample per clock with a valid strobe, together with the gain and volume settings that apply to that sample. The datapath returns the tuned sample with its own valid flag a fixed number of cycles later.

Top module: `hafd_top`

## Requirements
- R1: A synchronous reset (active high) clears res_vld to 0, res_out to 0 and every delay-line entry to 0. The first four samples after reset therefore use 0 as their sample from four positions back.
- R2: A sample accepted on a rising edge with smp_vld high produces exactly one res_vld pulse. The pulse is seen after the second rising edge that follows the accepting edge, so the latency is three edges including the accepting one. Samples may arrive on back-to-back cycles.
- R3: With d = floor((x[n] − x[n−4]) / 2), the pass-band term is (1 + gain_bp) · d. Gains are unsigned 0..15, and samples are two's complement.
- R4: With s = floor((x[n] + x[n−4]) / 2), the rejection term is gain_na · gain_nb · s. It is subtracted from the pass-band term.
- R5: The difference is multiplied by vol_code, which is unsigned 0..15. A vol_code of 0 yields an output of exactly 0.
- R6: The final value saturates to the signed 24-bit range, −8388608..8388607, and does not wrap.
- R7: The delay line advances only on accepted samples. smp_in and the gain inputs have no effect on later results during cycles with smp_vld low.
- R8: The gain and volume inputs are captured with each sample. A change applies to exactly the sample presented with it.
- R9: res_out keeps its last value whenever res_vld is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe; smp_in and the settings are taken when high |
| smp_in | input | 16 | Signed audio sample |
| gain_bp | input | 4 | Pass-band gain G (term weighted by 1+G) |
| gain_na | input | 4 | First rejection-term gain |
| gain_nb | input | 4 | Second rejection-term gain |
| vol_code | input | 4 | Volume multiplier |
| res_out | output | 24 | Signed tuned output sample |
| res_vld | output | 1 | Pulses once per accepted sample |

## Verification
The bench runs an impulse straight after reset. A delay line that did not clear would leak stale history into the first four outputs. Inputs with opposite full-scale extremes push the result past both 24-bit limits, which a wrapping final stage would turn into a wildly wrong sign. The bench toggles junk onto the data and gain inputs while the strobe is low. This shows whether the delay line or a settings register is loaded when it should not be, which would shift which sample counts as four back. Gains change on every sample, vol_code 0 is tried, and odd differences check that the halving rounds toward minus infinity rather than toward zero.

// File: rtl/hafd_pkg.sv
package hafd_pkg;
   localparam int unsigned HAFD_SMP_W  = 16;
   localparam int unsigned HAFD_GAIN_W = 4;
   localparam int unsigned HAFD_TAPS   = 4;
   localparam int unsigned HAFD_OUT_W  = 24;

   // Result width of a signed-by-unsigned shift-and-select product.
   function automatic int unsigned prod_width(input int unsigned a_w, input int unsigned b_w);
      return a_w + b_w;
   endfunction
endpackage

// File: rtl/hafd_delay.sv
module hafd_delay #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv,
   input  logic signed [W-1:0] d,
   output logic signed [W-1:0] tap
);
   logic [DEPTH-1:0][W-1:0] q;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("hafd_delay: DEPTH must be at least 1");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) begin
               q[i] <= '0;
            end else if (adv) begin
               if (i == 0) q[i] <= d;
               else        q[i] <= q[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   assign tap = q[DEPTH-1];

   AST_DLY_HOLD: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(q));  // R7
   AST_DLY_LOAD: assert property (@(posedge clk) disable iff (rst)
      adv |=> q[0] == $past(d));  // R7
endmodule

// File: rtl/hafd_shadd_mul.sv
module hafd_shadd_mul #(
   parameter int unsigned A_W = 16,
   parameter int unsigned B_W = 4,
   localparam int unsigned P_W = A_W + B_W
) (
   input  logic signed [A_W-1:0] a,
   input  logic        [B_W-1:0] b,
   output logic signed [P_W-1:0] p
);
   logic signed [P_W-1:0] a_ext;
   logic signed [P_W-1:0] pick [B_W];

   assign a_ext = P_W'(a);

   generate
      if (B_W < 1 || B_W > 8) begin : g_bad_b
         $error("hafd_shadd_mul: B_W must be 1..8");
      end
      for (genvar i = 0; i < B_W; i++) begin : g_pick
         assign pick[i] = b[i] ? (a_ext <<< i) : '0;
      end
   endgenerate

   always_comb begin
      p = '0;
      for (int i = 0; i < B_W; i++) begin
         p = p + pick[i];
      end
   end
endmodule

// File: rtl/hafd_top.sv
module hafd_top
   import hafd_pkg::*;
#(
   parameter int unsigned SMP_W    = HAFD_SMP_W,
   parameter int unsigned GAIN_W   = HAFD_GAIN_W,
   parameter int unsigned TAPS     = HAFD_TAPS,
   parameter int unsigned OUT_W    = HAFD_OUT_W,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_vld,
   input  logic signed [SMP_W-1:0] smp_in,
   input  logic [GAIN_W-1:0]       gain_bp,
   input  logic [GAIN_W-1:0]       gain_na,
   input  logic [GAIN_W-1:0]       gain_nb,
   input  logic [GAIN_W-1:0]       vol_code,
   output logic signed [OUT_W-1:0] res_out,
   output logic                    res_vld
);
   localparam int unsigned BP_W   = prod_width(SMP_W, GAIN_W);
   localparam int unsigned NP_W   = prod_width(BP_W, GAIN_W);
   localparam int unsigned DIFF_W = NP_W + 1;
   localparam int unsigned PROD_W = prod_width(DIFF_W, GAIN_W);
   localparam logic signed [PROD_W-1:0] LIM_HI =
      {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [PROD_W-1:0] LIM_LO = ~LIM_HI;
   localparam logic signed [OUT_W-1:0]  OUT_HI = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0]  OUT_LO = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (SMP_W < 4) begin : g_bad_smp
         $error("hafd_top: SMP_W too small");
      end
      if (OUT_W > PROD_W || OUT_W < SMP_W) begin : g_bad_out
         $error("hafd_top: OUT_W must lie between SMP_W and the full product width");
      end
   endgenerate

   // ---------------- stage 1: delay line and wired halving ----------------
   logic signed [SMP_W-1:0] old_smp;
   logic signed [SMP_W:0]   dif_w, sum_w;

   hafd_delay #(.W(SMP_W), .DEPTH(TAPS)) u_dly (
      .clk (clk),
      .rst (rst),
      .adv (smp_vld),
      .d   (smp_in),
      .tap (old_smp)
   );

   assign dif_w = (SMP_W+1)'(smp_in) - (SMP_W+1)'(old_smp);
   assign sum_w = (SMP_W+1)'(smp_in) + (SMP_W+1)'(old_smp);

   logic                    v1;
   logic signed [SMP_W-1:0] s1_hd, s1_hs;
   logic [GAIN_W-1:0]       s1_gbp, s1_gna, s1_gnb, s1_vol;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1     <= 1'b0;
         s1_hd  <= '0;
         s1_hs  <= '0;
         s1_gbp <= '0;
         s1_gna <= '0;
         s1_gnb <= '0;
         s1_vol <= '0;
      end else begin
         v1 <= smp_vld;
         if (smp_vld) begin
            s1_hd  <= SMP_W'(dif_w >>> 1);
            s1_hs  <= SMP_W'(sum_w >>> 1);
            s1_gbp <= gain_bp;
            s1_gna <= gain_na;
            s1_gnb <= gain_nb;
            s1_vol <= vol_code;
         end
      end
   end

   // ---------------- stage 2: first gain multiplies ----------------
   logic signed [BP_W-1:0] bp_mul, np_mul;

   hafd_shadd_mul #(.A_W(SMP_W), .B_W(GAIN_W)) u_mul_bp (
      .a (s1_hd), .b (s1_gbp), .p (bp_mul)
   );
   hafd_shadd_mul #(.A_W(SMP_W), .B_W(GAIN_W)) u_mul_na (
      .a (s1_hs), .b (s1_gna), .p (np_mul)
   );

   logic                   v2;
   logic signed [BP_W-1:0] s2_bp, s2_np;
   logic [GAIN_W-1:0]      s2_gnb, s2_vol;

   always_ff @(posedge clk) begin
      if (rst) begin
         v2     <= 1'b0;
         s2_bp  <= '0;
         s2_np  <= '0;
         s2_gnb <= '0;
         s2_vol <= '0;
      end else begin
         v2 <= v1;
         if (v1) begin
            s2_bp  <= bp_mul + BP_W'(s1_hd);
            s2_np  <= np_mul;
            s2_gnb <= s1_gnb;
            s2_vol <= s1_vol;
         end
      end
   end

   // ---------------- stage 3: second gain, combine, volume, clip ----------------
   logic signed [NP_W-1:0]   notch;
   logic signed [DIFF_W-1:0] diff;
   logic signed [PROD_W-1:0] vol_prod;
   logic signed [OUT_W-1:0]  res_next;

   hafd_shadd_mul #(.A_W(BP_W), .B_W(GAIN_W)) u_mul_nb (
      .a (s2_np), .b (s2_gnb), .p (notch)
   );

   assign diff = DIFF_W'(s2_bp) - DIFF_W'(notch);

   hafd_shadd_mul #(.A_W(DIFF_W), .B_W(GAIN_W)) u_mul_vol (
      .a (diff), .b (s2_vol), .p (vol_prod)
   );

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (vol_prod > LIM_HI)      res_next = OUT_HI;
            else if (vol_prod < LIM_LO) res_next = OUT_LO;
            else                        res_next = OUT_W'(vol_prod);
         end
         AST_SAT_HI: assert property (@(posedge clk) disable iff (rst)
            (v2 && vol_prod > LIM_HI) |=> res_out == OUT_HI);  // R6
         AST_SAT_LO: assert property (@(posedge clk) disable iff (rst)
            (v2 && vol_prod < LIM_LO) |=> res_out == OUT_LO);  // R6
      end else begin : g_wrap
         assign res_next = OUT_W'(vol_prod);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         res_vld <= 1'b0;
         res_out <= '0;
      end else begin
         res_vld <= v2;
         if (v2) res_out <= res_next;
      end
   end

   AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> v1);  // R2
   AST_STAGE_FWD: assert property (@(posedge clk) disable iff (rst)
      v1 |=> v2);  // R2
   AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !v1 |=> !v2);  // R2
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
      !v2 |=> (!res_vld && $stable(res_out)));  // R9
   AST_VOL_ZERO: assert property (@(posedge clk) disable iff (rst)
      (v2 && s2_vol == '0) |=> res_out == '0);  // R5
endmodule

// File: tb/tb_hafd_top.sv
module tb_hafd_top;
   logic               clk = 1'b0;
   logic               rst;
   logic               smp_vld;
   logic signed [15:0] smp_in;
   logic [3:0]         gain_bp, gain_na, gain_nb, vol_code;
   logic signed [23:0] res_out;
   logic               res_vld;

   hafd_top dut (
      .clk      (clk),
      .rst      (rst),
      .smp_vld  (smp_vld),
      .smp_in   (smp_in),
      .gain_bp  (gain_bp),
      .gain_na  (gain_na),
      .gain_nb  (gain_nb),
      .vol_code (vol_code),
      .res_out  (res_out),
      .res_vld  (res_vld)
   );

   always #10 clk = ~clk;

   int     n_chk  = 0;
   int     n_fail = 0;
   longint cyc    = 0;
   longint hist [4];
   longint exp_q [$];
   longint acc_q [$];
   string  tag_q [$];
   logic signed [23:0] last_out = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input longint act, input longint expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic longint clip24(input longint v);
      if (v > 64'sd8388607)  return 64'sd8388607;
      if (v < -64'sd8388608) return -64'sd8388608;
      return v;
   endfunction

   // Reference: built from the requirement formulas in full precision.
   task automatic send(input string tag, input longint x,
                       input int g, input int na, input int nb, input int v);
      longint x4, d, s, r;
      @(negedge clk);
      smp_vld  = 1'b1;
      smp_in   = 16'(x);
      gain_bp  = 4'(g);
      gain_na  = 4'(na);
      gain_nb  = 4'(nb);
      vol_code = 4'(v);
      x4 = hist[3];
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = x;
      d = (x - x4) >>> 1;
      s = (x + x4) >>> 1;
      r = longint'(v) * ((1 + longint'(g)) * d - longint'(na) * longint'(nb) * s);
      exp_q.push_back(clip24(r));
      acc_q.push_back(cyc + 1);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_vld  = 1'b0;
         smp_in   = 16'($urandom);
         gain_bp  = 4'($urandom);
         gain_na  = 4'($urandom);
         gain_nb  = 4'($urandom);
         vol_code = 4'($urandom);
      end
   endtask

   // Output monitor: value, latency (R2) and hold behaviour (R9).
   always @(negedge clk) begin
      if (rst === 1'b0) begin
         if (res_vld) begin
            if (exp_q.size() == 0) begin
               chk("R2 spurious res_vld", 1, 0);
            end else begin
               chk(tag_q[0], longint'(res_out), exp_q[0]);
               chk("R2 latency", cyc, acc_q[0] + 2);
               void'(exp_q.pop_front());
               void'(acc_q.pop_front());
               void'(tag_q.pop_front());
            end
            last_out = res_out;
         end else if (res_out !== last_out) begin
            chk("R9 hold", longint'(res_out), longint'(last_out));
         end
      end
   end

   task automatic t_reset;
      rst = 1'b1; smp_vld = 1'b0; smp_in = 16'sd1234;
      gain_bp = 4'd5; gain_na = 4'd5; gain_nb = 4'd5; vol_code = 4'd5;
      for (int i = 0; i < 4; i++) hist[i] = 0;
      repeat (4) @(negedge clk);
      chk("R1 res_vld after reset", longint'(res_vld), 0);
      chk("R1 res_out after reset", longint'(res_out), 0);
      rst = 1'b0;
      idle(2);
      chk("R1 no output while idle", longint'(res_vld), 0);
   endtask

   task automatic t_impulse;
      send("R1 R3 R4 impulse", 1001, 3, 2, 1, 1);
      for (int i = 0; i < 5; i++) send("R1 R3 R4 impulse tail", 0, 3, 2, 1, 1);
      idle(4);
   endtask

   task automatic t_gain_sweep;
      for (int i = 0; i < 16; i++)
         send("R8 per-sample gains", 700 - 97 * i, i, 15 - i, (i * 7) % 16, (i * 3) % 16);
      idle(4);
   endtask

   task automatic t_vol_zero;
      send("R5 vol zero", 30000, 15, 15, 15, 0);
      send("R5 vol zero", -30000, 15, 15, 15, 0);
      send("R5 vol one", -3, 1, 1, 1, 1);
      idle(4);
   endtask

   task automatic t_saturate;
      for (int i = 0; i < 4; i++) send("R6 setup", -32768, 0, 0, 0, 1);
      send("R6 clip high", 0, 15, 15, 15, 15);
      for (int i = 0; i < 3; i++) send("R6 setup", 0, 0, 0, 0, 1);
      send("R6 setup", 32767, 0, 0, 0, 1);
      for (int i = 0; i < 3; i++) send("R6 setup", 0, 0, 0, 0, 1);
      send("R6 clip low", 0, 15, 15, 15, 15);
      idle(4);
   endtask

   task automatic t_gaps;
      for (int i = 0; i < 12; i++) begin
         send("R7 gapped samples", 4000 * (i - 6) + 17, 2, 3, 4, 5);
         idle(1 + (i % 3));
      end
      idle(4);
   endtask

   task automatic t_random;
      for (int i = 0; i < 300; i++) begin
         send("R3 R4 random", longint'($signed(16'($urandom))),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
         if ((i % 17) == 0) idle(1);
      end
      idle(6);
   endtask

   initial begin
      t_reset;
      t_impulse;
      t_gain_sweep;
      t_vol_zero;
      t_saturate;
      t_gaps;
      t_random;
      chk("R2 all results delivered", longint'(exp_q.size()), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule